// File: doc/BRIEF.md
# Interrupt Vector Dispatch Register

This block takes an interrupt vector from an external interrupt source and turns it into a vector trap for the processor core. The source drives a level input together with a 6-bit interrupt number. When the level goes high and no vector is pending, the block captures the number, marks itself busy and raises a hard-interrupt request. It also selects the vector trap type and gives the core a one-cycle wake pulse so that a halted core resumes.

Software reads three 64-bit data words and a status byte. The busy flag in the status byte guards the captured data. While it is set, the number input is ignored. The source withdraws the vector by driving the level low, which clears busy and drops the request. The captured words keep their contents until the next capture.

Top module: `ivd_dispatch`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are: `busy_o`=0, `status_o`=0, `hard_irq_o`=0, `wake_o`=0, `trap_type_o`=0, and all three data words 0.
- R2: When the level is high at an edge while busy is clear, the following cycle shows `busy_o`=1, status bit 5 set, `hard_irq_o`=1 and `trap_type_o`=9'h060.
- R3: On capture, data word 0 becomes the interrupt number in bits 5:0 and 5'h1F in bits 10:6, with all higher bits zero. For example, number 0x2A gives 0x7EA.
- R4: On capture, data words 1 and 2 are zero.
- R5: While busy is set, a high level has no effect. The data words stay unchanged even if the number changes, and busy, request and trap type stay asserted.
- R6: A low level at an edge while busy is set clears busy, status bit 5 and `hard_irq_o` in the next cycle, and sets `trap_type_o` to 0. The data words keep their captured values.
- R7: A low level while busy is already clear has no effect. All outputs keep their values.
- R8: `wake_o` is high for exactly the one cycle that follows a capture, and low at all other times.
- R9: Status bits other than bit 5 always read 0.
- R10: After a release, a new high level captures again with the new number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_level_i | input | 1 | Vector level from the interrupt source |
| vec_num_i | input | 6 | Interrupt number carried with the vector |
| busy_o | output | 1 | Vector pending |
| status_o | output | 8 | Status byte; bit 5 is busy |
| data0_o | output | 64 | Data word 0: tag and interrupt number |
| data1_o | output | 64 | Data word 1 |
| data2_o | output | 64 | Data word 2 |
| hard_irq_o | output | 1 | Hard-interrupt request to the core |
| trap_type_o | output | 9 | Selected trap type, 0x060 while a vector is pending |
| wake_o | output | 1 | One-cycle wake pulse for a halted core |

## Verification
All state sits one register away from the ports, so a corrupted busy flag shows up in the cycle right after the edge that set it. It appears at the same time on `busy_o`, status bit 5, `hard_irq_o` and `trap_type_o`. A busy flag that fails to block capture shows up as a change in data word 0 on the edge after the number changes while the level is held high. A missing or stretched wake pulse is visible one cycle after capture.

// File: rtl/ivd_pkg.sv
package ivd_pkg;
  localparam int unsigned TT_W     = 9;
  localparam logic [8:0]  TT_VECTOR = 9'h060;
  localparam int unsigned TAG_W    = 5;
  localparam logic [4:0]  TAG_VAL  = 5'h1F;
  localparam int unsigned N_WORDS  = 3;

  typedef enum logic [1:0] {
    CMD_NONE    = 2'd0,
    CMD_CAPTURE = 2'd1,
    CMD_RELEASE = 2'd2
  } ivd_cmd_e;
endpackage

// File: rtl/ivd_decode.sv
module ivd_decode
  import ivd_pkg::*;
(
  input  logic     level_i,
  input  logic     busy_i,
  output ivd_cmd_e cmd_o
);
  always_comb begin
    cmd_o = CMD_NONE;
    if (level_i && !busy_i)      cmd_o = CMD_CAPTURE;
    else if (!level_i && busy_i) cmd_o = CMD_RELEASE;
  end
endmodule

// File: rtl/ivd_ctrl.sv
module ivd_ctrl
  import ivd_pkg::*;
#(
  parameter int unsigned STAT_W   = 8,
  parameter int unsigned BUSY_BIT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  ivd_cmd_e          cmd_i,
  output logic              busy_o,
  output logic [STAT_W-1:0] status_o,
  output logic              hard_irq_o,
  output logic [TT_W-1:0]   trap_type_o,
  output logic              wake_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o      <= 1'b0;
      status_o    <= '0;
      hard_irq_o  <= 1'b0;
      trap_type_o <= '0;
      wake_o      <= 1'b0;
    end else begin
      wake_o <= 1'b0;
      case (cmd_i)
        CMD_CAPTURE: begin
          busy_o             <= 1'b1;
          status_o           <= '0;
          status_o[BUSY_BIT] <= 1'b1;
          hard_irq_o         <= 1'b1;
          trap_type_o        <= TT_VECTOR;
          wake_o             <= 1'b1;
        end
        CMD_RELEASE: begin
          busy_o      <= 1'b0;
          status_o    <= '0;
          hard_irq_o  <= 1'b0;
          trap_type_o <= '0;
        end
        default: ;
      endcase
    end
  end

  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == CMD_CAPTURE) |=> (busy_o && hard_irq_o && trap_type_o == TT_VECTOR));
  a_r9_status_bits: assert property (@(posedge clk) disable iff (rst)
    $countones(status_o) == (busy_o ? 1 : 0));
endmodule

// File: rtl/ivd_capture.sv
module ivd_capture
  import ivd_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned NUM_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  ivd_cmd_e          cmd_i,
  input  logic [NUM_W-1:0]  num_i,
  output logic [DATA_W-1:0] word_o [N_WORDS]
);
  localparam int unsigned TAG_LSB = NUM_W;

  logic [DATA_W-1:0] word0_next;

  always_comb begin
    word0_next = '0;
    word0_next[NUM_W-1:0]        = num_i;
    word0_next[TAG_LSB +: TAG_W] = TAG_VAL;
  end

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        word_o[w] <= '0;
      end else if (cmd_i == CMD_CAPTURE) begin
        if (w == 0) word_o[w] <= word0_next;
        else        word_o[w] <= '0;
      end
    end
  end

  a_r3_num_field: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == CMD_CAPTURE) |=> (word_o[0][NUM_W-1:0] == $past(num_i)));
endmodule

// File: rtl/ivd_dispatch.sv
module ivd_dispatch
  import ivd_pkg::*;
#(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned NUM_W    = 6,
  parameter int unsigned STAT_W   = 8,
  parameter int unsigned BUSY_BIT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vec_level_i,
  input  logic [NUM_W-1:0]  vec_num_i,
  output logic              busy_o,
  output logic [STAT_W-1:0] status_o,
  output logic [DATA_W-1:0] data0_o,
  output logic [DATA_W-1:0] data1_o,
  output logic [DATA_W-1:0] data2_o,
  output logic              hard_irq_o,
  output logic [TT_W-1:0]   trap_type_o,
  output logic              wake_o
);
  ivd_cmd_e          cmd;
  logic [DATA_W-1:0] words [N_WORDS];

  ivd_decode u_decode (
    .level_i (vec_level_i),
    .busy_i  (busy_o),
    .cmd_o   (cmd)
  );

  ivd_ctrl #(.STAT_W(STAT_W), .BUSY_BIT(BUSY_BIT)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .cmd_i       (cmd),
    .busy_o      (busy_o),
    .status_o    (status_o),
    .hard_irq_o  (hard_irq_o),
    .trap_type_o (trap_type_o),
    .wake_o      (wake_o)
  );

  ivd_capture #(.DATA_W(DATA_W), .NUM_W(NUM_W)) u_capture (
    .clk    (clk),
    .rst    (rst),
    .cmd_i  (cmd),
    .num_i  (vec_num_i),
    .word_o (words)
  );

  assign data0_o = words[0];
  assign data1_o = words[1];
  assign data2_o = words[2];

  a_r3_tag: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> (data0_o[NUM_W +: TAG_W] == TAG_VAL));
  a_r4_zero_words: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> (data1_o == '0 && data2_o == '0));
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (vec_level_i && busy_o) |=> (busy_o && $stable(data0_o) && hard_irq_o));
  a_r6_release: assert property (@(posedge clk) disable iff (rst)
    (!vec_level_i && busy_o) |=> (!busy_o && !hard_irq_o && $stable(data0_o)));
  a_r7_idle_low: assert property (@(posedge clk) disable iff (rst)
    (!vec_level_i && !busy_o) |=> (!busy_o && $stable(data0_o) && !wake_o));
  a_r8_wake_pulse: assert property (@(posedge clk) disable iff (rst)
    wake_o |=> !wake_o);
  a_r8_wake_busy: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> busy_o);
endmodule

// File: tb/ivd_dispatch_tb.sv
module ivd_dispatch_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lvl = 1'b0;
  logic [5:0]  num = '0;
  logic        busy, hirq, wake;
  logic [7:0]  status;
  logic [63:0] d0, d1, d2;
  logic [8:0]  tt;

  int unsigned n_checks = 0;
  int unsigned n_errors = 0;
  bit          finished = 0;

  always #4 clk = ~clk;

  ivd_dispatch u_dut (
    .clk (clk), .rst (rst), .vec_level_i (lvl), .vec_num_i (num),
    .busy_o (busy), .status_o (status), .data0_o (d0), .data1_o (d1),
    .data2_o (d2), .hard_irq_o (hirq), .trap_type_o (tt), .wake_o (wake)
  );

  // entry: {level, num[5:0], exp_busy, exp_data0[11:0], exp_wake}
  localparam int NV = 8;
  localparam logic [20:0] TBL [NV] = '{
    {1'b0, 6'h05, 1'b0, 12'h000, 1'b0},
    {1'b1, 6'h2A, 1'b1, 12'h7EA, 1'b1},
    {1'b1, 6'h11, 1'b1, 12'h7EA, 1'b0},
    {1'b0, 6'h11, 1'b0, 12'h7EA, 1'b0},
    {1'b0, 6'h3F, 1'b0, 12'h7EA, 1'b0},
    {1'b1, 6'h3F, 1'b1, 12'h7FF, 1'b1},
    {1'b0, 6'h00, 1'b0, 12'h7FF, 1'b0},
    {1'b1, 6'h00, 1'b1, 12'h7C0, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic l, input logic [5:0] n);
    @(negedge clk);
    lvl = l;
    num = n;
    @(posedge clk);
    #1;
  endtask

  task automatic chk_state(input logic eb, input logic [63:0] ed0, input logic ew);
    chk(busy == eb, "R2 busy", busy, eb);
    chk(status == {2'b00, eb, 5'b00000}, "R9 status", status, {2'b00, eb, 5'b00000});
    chk(hirq == eb, "R2 hard_irq", hirq, eb);
    chk(tt == (eb ? 9'h060 : 9'h000), "R2 trap_type", tt, eb ? 9'h060 : 9'h000);
    chk(d0 == ed0, "R3 data0", d0, ed0);
    chk(d1 == 64'd0 && d2 == 64'd0, "R4 data1/2", d1 | d2, 64'd0);
    chk(wake == ew, "R8 wake", wake, ew);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    lvl = 1'b1; num = 6'h3F;
    repeat (3) @(posedge clk);
    #1;
    chk(busy == 0 && hirq == 0 && wake == 0 && tt == 0 && status == 0,
        "R1 reset ctrl", {busy, hirq, wake, tt}, 0);
    chk(d0 == 0 && d1 == 0 && d2 == 0, "R1 reset data", d0 | d1 | d2, 0);
    @(negedge clk);
    rst = 1'b0; lvl = 1'b0;

    // vector table
    for (int i = 0; i < NV; i++) begin
      step(TBL[i][20], TBL[i][19:14]);
      chk_state(TBL[i][13], {52'd0, TBL[i][12:1]}, TBL[i][0]);
    end

    // R5: held level while busy, number changes repeatedly
    for (int k = 1; k < 5; k++) begin
      step(1'b1, 6'(k * 7));
      chk(d0 == 64'h7C0, "R5 data0 held", d0, 64'h7C0);
      chk(busy && hirq && tt == 9'h060 && !wake, "R5 ctrl held",
          {busy, hirq, tt, wake}, {1'b1, 1'b1, 9'h060, 1'b0});
    end

    // R6: release keeps data
    step(1'b0, 6'h15);
    chk(!busy && !hirq && tt == 0 && status == 0, "R6 release ctrl",
        {busy, hirq, tt}, 0);
    chk(d0 == 64'h7C0, "R6 data0 kept", d0, 64'h7C0);

    // R7: low while idle, twice
    step(1'b0, 6'h2B);
    step(1'b0, 6'h01);
    chk(!busy && !wake && d0 == 64'h7C0, "R7 idle low", d0, 64'h7C0);

    // R10: re-capture with a new number
    step(1'b1, 6'h15);
    chk(busy && wake && d0 == 64'h7D5, "R10 recapture", d0, 64'h7D5);
    step(1'b1, 6'h15);
    chk(!wake, "R8 wake single cycle", wake, 0);

    // R1: mid-run reset clears captured state
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk(!busy && !hirq && d0 == 0 && tt == 0, "R1 mid-run reset", d0, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule